// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block timestamps external events for a 16-bit timer. One of two event inputs is selected: a capture pin or a comparator output. The selected level passes through a two-flop synchronizer. An optional digital filter can follow, and it accepts a new level only after four consecutive samples agree. A rising or falling edge then copies the running counter value into a 16-bit capture register and raises a sticky flag. The flag, gated by an enable, forms the interrupt request.

Software reaches the register over a small byte-wide bus. Reading the low byte copies the high byte into a holding byte, so the two reads return one consistent 16-bit value. When the timer runs in a mode where the capture register acts as the counter's TOP value, event captures stop. The register can then be loaded by writing the high byte first and the low byte second. The counter, the prescaler and the interrupt controller are outside this block. The filter runs on the system clock whatever the timer prescaler is set to.

Top module: `filtered_capture`

## Requirements
- R1: With `src_sel_i`=0 the capture pin is the event source; with `src_sel_i`=1 the comparator input is the event source. The unselected input has no effect.
- R2: `edge_rise_i`=1 captures on a 0→1 transition of the source and `edge_rise_i`=0 captures on a 1→0 transition. The opposite transition captures nothing. With the filter off, a change driven before clock edge k loads `cap_o` at edge k+2 with the `cnt_i` value sampled at that edge.
- R3: With `filt_en_i`=1, a source pulse lasting three clocks causes no capture, while a pulse lasting four clocks is accepted.
- R4: The filter adds exactly four clocks: a change before edge k is captured at edge k+6.
- R5: A capture sets `flag_o`. A bus write to address 2 with data bit 0 set clears it, and data bit 0 clear leaves it unchanged. If a capture and a clear land on the same edge, the flag stays set.
- R6: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R7: A new capture overwrites `cap_o` even when the previous value was never read.
- R8: Changing `src_sel_i` so that the selected level changes in the enabled direction produces a capture, with the same timing as a pin edge. Software can then clear the flag.
- R9: While `top_mode_i`=1 no event captures occur. A write to address 1 (high byte) followed by a write to address 0 (low byte) loads all 16 bits of `cap_o` at the low-byte write.
- R10: With `top_mode_i`=0, low-byte writes leave `cap_o` unchanged.
- R11: Reads return data on `bus_rdata_o` one clock after the read strobe. Address 0 returns `cap_o[7:0]` and copies `cap_o[15:8]` into the holding byte. Address 1 returns the holding byte. Address 2 returns the flag in bit 0.
- R12: After reset `cap_o`, `flag_o`, `irq_o` and `bus_rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Running timer count |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| cmp_i | input | 1 | Comparator output, alternate source |
| src_sel_i | input | 1 | 0 = pin, 1 = comparator |
| filt_en_i | input | 1 | Four-sample filter enable |
| edge_rise_i | input | 1 | 1 = rising, 0 = falling edge |
| top_mode_i | input | 1 | Capture register used as TOP |
| irq_en_i | input | 1 | Interrupt enable |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 2 | 0 low byte, 1 high byte, 2 flag |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Registered bus read data |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
An event change driven before edge k appears in `cap_o` and `flag_o` at edge k+2 with the filter off, or at edge k+6 with it on. The stored value is the counter sampled at that edge. The bench drives inputs on falling edges and notes the count at that moment. It samples one falling edge before the due edge to confirm nothing moved early, then samples again right after the due edge. Bus writes take effect on the next rising edge and read data is valid one clock after the strobe, so every bus check samples at the falling edge that follows.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int HIST = SAMPLES - 1;

  logic [HIST-1:0] hist;
  logic [SAMPLES-1:0] window;
  logic agree;
  logic q_r;

  assign window = {hist, d};
  assign agree  = (&window) | ~(|window);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      q_r  <= 1'b0;
    end else begin
      hist <= window[HIST-1:0];
      if (agree && (d != q_r)) q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic rise_sel,
  input  logic gate,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sig;
  end

  assign evt = gate & (rise_sel ? (sig & ~prev) : (~sig & prev));
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         evt,
  input  logic         top_mode,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W/2-1:0] wdata,
  output logic [W/2-1:0] rdata,
  output logic [W-1:0] cap,
  output logic         flag
);
  localparam int BYTE = W / 2;

  logic [BYTE-1:0] hold;
  logic wr_lo, wr_hi, wr_flag, rd_lo;

  assign wr_lo   = wr_en & (addr == ADDR_LO);
  assign wr_hi   = wr_en & (addr == ADDR_HI);
  assign wr_flag = wr_en & (addr == ADDR_FLAG);
  assign rd_lo   = rd_en & (addr == ADDR_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap   <= '0;
      hold  <= '0;
      flag  <= 1'b0;
      rdata <= '0;
    end else begin
      if (evt)                    cap <= cnt;
      else if (wr_lo && top_mode) cap <= {hold, wdata};

      if (wr_hi)      hold <= wdata;
      else if (rd_lo) hold <= cap[W-1:BYTE];

      if (evt)                       flag <= 1'b1;
      else if (wr_flag && wdata[0])  flag <= 1'b0;

      if (rd_en) begin
        case (addr)
          ADDR_LO:   rdata <= cap[BYTE-1:0];
          ADDR_HI:   rdata <= hold;
          ADDR_FLAG: rdata <= {{(BYTE-1){1'b0}}, flag};
          default:   rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/filtered_capture.sv
module filtered_capture #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_SAMPLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          cap_pin_i,
  input  logic          cmp_i,
  input  logic          src_sel_i,
  input  logic          filt_en_i,
  input  logic          edge_rise_i,
  input  logic          top_mode_i,
  input  logic          irq_en_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [CW/2-1:0] bus_wdata_i,
  output logic [CW/2-1:0] bus_rdata_o,
  output logic [CW-1:0] cap_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic raw_sel;
  logic sync_sel;
  logic filt_q;
  logic det_in;
  logic cap_evt;

  assign raw_sel = src_sel_i ? cmp_i : cap_pin_i;

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_sel), .q(sync_sel)
  );

  icu_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst(rst), .d(sync_sel), .q(filt_q)
  );

  assign det_in = filt_en_i ? filt_q : sync_sel;

  icu_edge u_edge (
    .clk(clk), .rst(rst), .sig(det_in), .rise_sel(edge_rise_i),
    .gate(~top_mode_i), .evt(cap_evt)
  );

  icu_regs #(.W(CW)) u_regs (
    .clk(clk), .rst(rst), .cnt(cnt_i), .evt(cap_evt),
    .top_mode(top_mode_i), .wr_en(bus_wr_i), .rd_en(bus_rd_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .rdata(bus_rdata_o),
    .cap(cap_o), .flag(flag_o)
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/fcap_checker.sv
module fcap_checker
  import icu_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          top_mode_i,
  input logic          bus_wr_i,
  input logic [1:0]    bus_addr_i,
  input logic [CW-1:0] cap_o,
  input logic          flag_o,
  input logic          cap_evt,
  input logic          sync_sel,
  input logic          filt_q
);
  p_top_hold_r9: assert property (@(posedge clk) disable iff (rst)
    top_mode_i && !(bus_wr_i && bus_addr_i == ADDR_LO) |=> $stable(cap_o));

  p_no_evt_in_top_r9: assert property (@(posedge clk) disable iff (rst)
    top_mode_i |-> !cap_evt);

  p_lo_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    !top_mode_i && !cap_evt |=> $stable(cap_o));

  p_evt_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag_o);

  p_flag_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(cap_evt));

  p_filter_agree_r3: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |->
      ($past(sync_sel, 1) == filt_q) && ($past(sync_sel, 2) == filt_q) &&
      ($past(sync_sel, 3) == filt_q) && ($past(sync_sel, 4) == filt_q));
endmodule

bind filtered_capture fcap_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .top_mode_i(top_mode_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .cap_o(cap_o), .flag_o(flag_o),
  .cap_evt(cap_evt), .sync_sel(sync_sel), .filt_q(filt_q)
);

// File: tb/tb_filtered_capture.sv
`timescale 1ns/1ps
module tb_filtered_capture;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [15:0] cnt_run = 16'd0;
  logic [15:0] ofs = 16'd0;
  logic [15:0] cnt_i;
  logic cap_pin_i, cmp_i, src_sel_i, filt_en_i, edge_rise_i, top_mode_i, irq_en_i;
  logic bus_wr_i, bus_rd_i;
  logic [1:0] bus_addr_i;
  logic [7:0] bus_wdata_i, bus_rdata_o;
  logic [15:0] cap_o;
  logic flag_o, irq_o;

  assign cnt_i = cnt_run + ofs;
  always @(posedge clk) cnt_run <= cnt_run + 16'd1;

  filtered_capture dut (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .cap_pin_i(cap_pin_i), .cmp_i(cmp_i),
    .src_sel_i(src_sel_i), .filt_en_i(filt_en_i), .edge_rise_i(edge_rise_i),
    .top_mode_i(top_mode_i), .irq_en_i(irq_en_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // {src, filt, rise, level driven, capture expected}
  localparam logic [4:0] VEC [8] = '{
    5'b00111, 5'b00100, 5'b00001, 5'b10111,
    5'b11001, 5'b01111, 5'b11100, 5'b00010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [15:0] c0, old, expv;
    logic [7:0] d;
    string tag;
    rst = 1'b1;
    cap_pin_i = 0; cmp_i = 0; src_sel_i = 0; filt_en_i = 0; edge_rise_i = 1;
    top_mode_i = 0; irq_en_i = 0; bus_wr_i = 0; bus_rd_i = 0;
    bus_addr_i = 0; bus_wdata_i = 0;
    repeat (4) @(negedge clk);
    chk("R12 cap", cap_o, 0);
    chk("R12 flag", flag_o, 0);
    chk("R12 irq", irq_o, 0);
    chk("R12 rdata", bus_rdata_o, 0);
    rst = 1'b0;
    @(negedge clk);
    bus_rd(2'd0, d); chk("R12 read lo", d, 0);

    // table of source/filter/edge combinations
    for (int i = 0; i < 8; i++) begin
      src_sel_i = VEC[i][4]; filt_en_i = VEC[i][3]; edge_rise_i = VEC[i][2];
      cap_pin_i = ~VEC[i][1]; cmp_i = ~VEC[i][1];
      repeat (12) @(negedge clk);
      bus_wr(2'd2, 8'h01);
      old = cap_o; c0 = cnt_i;
      if (VEC[i][4]) cmp_i = VEC[i][1]; else cap_pin_i = VEC[i][1];
      lat = VEC[i][3] ? 7 : 3;
      tag = VEC[i][3] ? "R4" : (VEC[i][4] ? "R1" : "R2");
      expv = c0 + 16'(lat - 1);
      repeat (lat - 1) @(negedge clk);
      chk({tag, " not early"}, cap_o, old);
      @(negedge clk);
      if (VEC[i][0]) begin
        chk({tag, " cap value"}, cap_o, expv);
        chk({tag, " flag"}, flag_o, 1);
      end else begin
        repeat (5) @(negedge clk);
        chk({tag, " wrong edge cap"}, cap_o, old);
        chk({tag, " wrong edge flag"}, flag_o, 0);
      end
    end

    // R3 glitch rejection and acceptance
    src_sel_i = 0; filt_en_i = 1; edge_rise_i = 1; cap_pin_i = 0; cmp_i = 0;
    repeat (12) @(negedge clk);
    bus_wr(2'd2, 8'h01);
    old = cap_o;
    cap_pin_i = 1; repeat (3) @(negedge clk); cap_pin_i = 0;
    repeat (12) @(negedge clk);
    chk("R3 short pulse cap", cap_o, old);
    chk("R3 short pulse flag", flag_o, 0);
    c0 = cnt_i;
    cap_pin_i = 1; repeat (4) @(negedge clk); cap_pin_i = 0;
    repeat (3) @(negedge clk);
    chk("R3 four-clock pulse cap", cap_o, c0 + 16'd6);
    chk("R3 four-clock pulse flag", flag_o, 1);
    repeat (12) @(negedge clk);

    // R7 overwrite
    filt_en_i = 0;
    repeat (6) @(negedge clk);
    bus_wr(2'd2, 8'h01);
    cap_pin_i = 1; repeat (5) @(negedge clk);
    cap_pin_i = 0; repeat (5) @(negedge clk);
    c0 = cnt_i; cap_pin_i = 1;
    repeat (3) @(negedge clk);
    chk("R7 overwritten value", cap_o, c0 + 16'd2);

    // R6 / R5 flag and interrupt
    irq_en_i = 1; @(negedge clk);
    chk("R6 irq on", irq_o, 1);
    bus_wr(2'd2, 8'h00);
    chk("R5 write zero keeps flag", flag_o, 1);
    irq_en_i = 0; @(negedge clk);
    chk("R6 irq masked", irq_o, 0);
    irq_en_i = 1;
    bus_wr(2'd2, 8'h01);
    chk("R5 flag cleared", flag_o, 0);
    chk("R6 irq after clear", irq_o, 0);
    cap_pin_i = 0; repeat (6) @(negedge clk);
    bus_wr(2'd2, 8'h01);
    c0 = cnt_i; cap_pin_i = 1;
    @(negedge clk); @(negedge clk);
    bus_wr(2'd2, 8'h01);
    chk("R5 capture beats clear", flag_o, 1);
    chk("R5 capture beats clear value", cap_o, c0 + 16'd2);
    irq_en_i = 0;

    // R8 source switch
    cap_pin_i = 0; cmp_i = 1; src_sel_i = 0;
    repeat (8) @(negedge clk);
    bus_wr(2'd2, 8'h01);
    c0 = cnt_i; src_sel_i = 1;
    repeat (3) @(negedge clk);
    chk("R8 switch flag", flag_o, 1);
    chk("R8 switch cap", cap_o, c0 + 16'd2);
    bus_wr(2'd2, 8'h01);
    chk("R8 flag cleared", flag_o, 0);

    // R9 TOP mode
    src_sel_i = 0; repeat (6) @(negedge clk);
    bus_wr(2'd2, 8'h01);
    top_mode_i = 1; @(negedge clk);
    old = cap_o;
    cap_pin_i = 1; repeat (3) @(negedge clk);
    cap_pin_i = 0; repeat (3) @(negedge clk);
    cap_pin_i = 1; repeat (8) @(negedge clk);
    chk("R9 no capture cap", cap_o, old);
    chk("R9 no capture flag", flag_o, 0);
    bus_wr(2'd1, 8'hAB);
    chk("R9 high alone no commit", cap_o, old);
    bus_wr(2'd0, 8'hCD);
    chk("R9 16-bit write", cap_o, 16'hABCD);
    bus_rd(2'd2, d); chk("R11 flag read", d, 0);
    cap_pin_i = 0; repeat (6) @(negedge clk);
    top_mode_i = 0; repeat (2) @(negedge clk);

    // R10 writes ignored outside TOP mode
    bus_wr(2'd1, 8'h11);
    bus_wr(2'd0, 8'h22);
    chk("R10 cap unchanged", cap_o, 16'hABCD);

    // R11 atomic read
    bus_rd(2'd0, d); chk("R11 low byte", d, 8'hCD);
    ofs = 16'h7700; @(negedge clk);
    c0 = cnt_i; cap_pin_i = 1;
    repeat (3) @(negedge clk);
    expv = c0 + 16'd2;
    chk("R2 capture with offset", cap_o, expv);
    bus_rd(2'd1, d); chk("R11 held high byte", d, 8'hAB);
    bus_rd(2'd0, d); chk("R11 new low", d, expv[7:0]);
    bus_rd(2'd1, d); chk("R11 new high", d, expv[15:8]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule